// File: doc/BRIEF.md
# DRAM Access Sequencer with Programmable Wait States

This block turns a single CPU memory-cycle strobe into the timed strobe sequence that a DRAM array with multiplexed address pins needs. The strobe carries an 18-bit word address, a read/write flag and the write data. The block captures all of them on the strobe. It presents the row half of the address, lowers the row strobe, switches the column half onto the same pins and lowers the column strobe. The DRAM returns no acknowledge, so the block raises its ready output when its own tick counter reaches a fixed point. A 2-bit wait-state setting delays that point by whole CPU clocks.

Every tick is one period of the sequencer clock, nominally 25 ns. One CPU clock equals five ticks. The state machine moves through six named states. **IDLE** goes to **ROW** when a strobe arrives. **ROW** (ticks 0 to 5) goes to **RASD** at tick 6. **RASD** goes to **CASD** at tick 7. **CASD** goes to **READY** at tick 11 + 5·ws. **READY** goes to **PRECH** after five ticks. **PRECH** lasts four ticks, then goes to ROW if a strobe is waiting or present, and otherwise to IDLE. A strobe that arrives while the block is busy waits in one pending slot.

Each data byte carries one odd-parity bit. The block generates this bit on writes and checks it on reads. A mismatch in any byte raises an error flag. An even number of flipped bits in one byte is not detected.

Top module: `dram_cycle_seq`

## Requirements
- R1: While reset is held, and after it until the first strobe, dram_ras_n, dram_cas_n and dram_we_n are 1, and cyc_ready and par_err are 0.
- R2: A strobe sampled at a clock edge is accepted if the block is idle, and that edge is tick 0. The address, write flag and write data are captured at that edge. dram_ras_n is 0 from tick 6 up to, but not including, the release tick E = 16 + 5·ws.
- R3: dram_col is 1 from tick 7 up to E. dram_a carries address bits [8:0] while dram_col is 0 and address bits [17:9] while dram_col is 1.
- R4: dram_cas_n is 0 from tick 7 up to E. It is never lowered unless dram_ras_n was already 0 in the tick before.
- R5: cyc_ready is 1 for exactly the five ticks 11 + 5·ws through 15 + 5·ws, where ws is the 2-bit wait-state setting.
- R6: dram_ras_n and dram_cas_n rise together at tick E. Ticks E to E+3 are precharge, in which no new cycle starts. The earliest next tick 0 is the edge at tick E+4.
- R7: A strobe accepted while a cycle or its precharge runs is held in one pending slot. Its cycle starts at the edge at tick E+4 of the running cycle, with the address it carried. A further strobe that arrives while the slot is full is dropped.
- R8: On a write cycle, dram_we_n is 0 from tick 6 up to E, and dram_dq_o carries the captured write data. On a read cycle, dram_we_n stays 1.
- R9: On writes, dram_dp_o[i] is the odd-parity bit of byte i of the write data. Byte i is bits [8i+7:8i]. The bit is 1 when that byte has an even number of ones.
- R10: On a read, cyc_rdata and par_err are loaded at the edge of tick 11 + 5·ws and held until the next read or write reaches that tick. par_err is 1 when any byte together with its dram_dp_i bit holds an even number of ones. A write cycle clears par_err at that tick.
- R11: Two flipped bits within one byte give par_err = 0.
- R12: ws_sel is sampled only at the tick-0 edge. A change later in the cycle does not move cyc_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer tick clock |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Memory-cycle strobe; address is valid with it |
| cyc_addr | input | 18 | Word address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_wdata | input | 16 | Write data |
| ws_sel | input | 2 | Wait-state count, 0 to 3 |
| cyc_ready | output | 1 | Ready back to the CPU |
| cyc_rdata | output | 16 | Captured read data |
| par_err | output | 1 | Read parity mismatch flag |
| dram_a | output | 9 | Shared row/column address pins |
| dram_col | output | 1 | Column half selected onto dram_a |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | 16 | Data toward the DRAM |
| dram_dp_o | output | 2 | Parity bits toward the DRAM |
| dram_dq_i | input | 16 | Data from the DRAM |
| dram_dp_i | input | 2 | Parity bits from the DRAM |

## Verification
Two things can fall in the same cycle: capturing a new strobe into the pending slot, and the running cycle driving its own captured address and strobes. The bench injects a second strobe in the middle of the column-strobe phase, and separately inside precharge. It checks that the running cycle's address halves and timing are unchanged. It then checks that the queued cycle's tick 0 lands exactly at tick E+4, with the queued address on the pins. A third strobe sent while the slot is full must leave the block idle after the queued cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_RASD,
        S_CASD,
        S_READY,
        S_PRECH
    } seq_state_t;

    // odd parity: set when the byte holds an even number of ones
    function automatic logic odd_bit(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dseq_pkg::*;
#(
    parameter int WS_W     = 2,
    parameter int RAS_TICK = 6,
    parameter int CAS_TICK = 7,
    parameter int RDY_BASE = 11,
    parameter int WS_STEP  = 5,
    parameter int RDY_LEN  = 5,
    parameter int PRE_LEN  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            pend_i,
    input  logic [WS_W-1:0] ws_i,
    output logic            begin_o,
    output logic            capture_o,
    output logic            busy_o,
    output logic            ras_o,
    output logic            cas_o,
    output logic            col_o,
    output logic            rdy_o
);

    localparam int MAX_T = RDY_BASE + WS_STEP * ((1 << WS_W) - 1) + RDY_LEN + PRE_LEN;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] T_RAS  = CNT_W'(RAS_TICK - 1);
    localparam logic [CNT_W-1:0] T_CAS  = CNT_W'(CAS_TICK - 1);
    localparam logic [CNT_W-1:0] RDY_HI = CNT_W'(RDY_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_HI = CNT_W'(RDY_LEN + PRE_LEN - 1);

    seq_state_t        state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [WS_W-1:0]   ws_q;
    logic [CNT_W-1:0]  rdy_at;

    assign rdy_at = CNT_W'(RDY_BASE) + CNT_W'(WS_STEP) * CNT_W'(ws_q);

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (start_i)                         state_n = S_ROW;
            S_ROW:   if (cnt == T_RAS)                    state_n = S_RASD;
            S_RASD:  if (cnt == T_CAS)                    state_n = S_CASD;
            S_CASD:  if (cnt == rdy_at - CNT_W'(1))       state_n = S_READY;
            S_READY: if (cnt == rdy_at + RDY_HI)          state_n = S_PRECH;
            S_PRECH: if (cnt == rdy_at + PRE_HI)
                         state_n = (start_i || pend_i) ? S_ROW : S_IDLE;
            default:                                      state_n = S_IDLE;
        endcase
    end

    assign begin_o   = (state_n == S_ROW) && (state != S_ROW);
    assign capture_o = (state == S_CASD) && (state_n == S_READY);
    assign busy_o    = (state != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            ws_q  <= '0;
        end else begin
            state <= state_n;
            if (begin_o) begin
                cnt  <= '0;
                ws_q <= ws_i;
            end else if (state != S_IDLE) begin
                cnt <= cnt + CNT_W'(1);
            end else begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        ras_o = 1'b0;
        cas_o = 1'b0;
        col_o = 1'b0;
        rdy_o = 1'b0;
        unique case (state)
            S_RASD: ras_o = 1'b1;
            S_CASD: begin
                ras_o = 1'b1;
                cas_o = 1'b1;
                col_o = 1'b1;
            end
            S_READY: begin
                ras_o = 1'b1;
                cas_o = 1'b1;
                col_o = 1'b1;
                rdy_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_o) |-> $past(ras_o));

    // R6
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_o) |-> $fell(cas_o));

    // R5
    ready_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> (cnt == rdy_at));

    // R12
    ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o && $past(ras_o)) |-> $stable(ws_q));

endmodule

// File: rtl/dseq_capture.sv
module dseq_capture #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              begin_i,
    input  logic              busy_i,
    input  logic              col_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pend_o,
    output logic              cur_we_o,
    output logic [DATA_W-1:0] cur_wdata_o,
    output logic [ADDR_W/2-1:0] mem_a_o
);

    localparam int HALF = ADDR_W / 2;

    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr, cur_addr;
    logic              pend_we;
    logic [DATA_W-1:0] pend_wdata;
    logic              take_pend, take_direct, park;

    assign take_pend   = begin_i && pend_q;
    assign take_direct = begin_i && !pend_q;
    assign park        = start_i && !begin_i && !pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr   <= '0;
            pend_we     <= 1'b0;
            pend_wdata  <= '0;
            cur_addr    <= '0;
            cur_we_o    <= 1'b0;
            cur_wdata_o <= '0;
        end else begin
            if (take_pend) begin
                cur_addr    <= pend_addr;
                cur_we_o    <= pend_we;
                cur_wdata_o <= pend_wdata;
                pend_q      <= start_i;
                if (start_i) begin
                    pend_addr  <= addr_i;
                    pend_we    <= we_i;
                    pend_wdata <= wdata_i;
                end
            end else if (take_direct) begin
                cur_addr    <= addr_i;
                cur_we_o    <= we_i;
                cur_wdata_o <= wdata_i;
            end else if (park) begin
                pend_q     <= 1'b1;
                pend_addr  <= addr_i;
                pend_we    <= we_i;
                pend_wdata <= wdata_i;
            end
        end
    end

    assign pend_o  = pend_q;
    assign mem_a_o = col_i ? cur_addr[ADDR_W-1:HALF] : cur_addr[HALF-1:0];

    // R3
    col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_i && $past(col_i)) |-> $stable(mem_a_o));

    // R7
    pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_i);

endmodule

// File: rtl/dseq_parity.sv
module dseq_parity
    import dseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic                cur_we_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [DATA_W-1:0]   rdata_i,
    input  logic [DATA_W/8-1:0] rpar_i,
    output logic [DATA_W/8-1:0] wpar_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                err_o
);

    localparam int NB = DATA_W / 8;

    logic [NB-1:0] bad;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign wpar_o[i] = odd_bit(wdata_i[8*i +: 8]);
        assign bad[i]    = ~(^{rdata_i[8*i +: 8], rpar_i[i]});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else if (capture_i) begin
            if (cur_we_i) begin
                err_o <= 1'b0;
            end else begin
                rdata_o <= rdata_i;
                err_o   <= |bad;
            end
        end
    end

    // R10
    err_moves_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(capture_i));

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dseq_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int WS_W     = 2,
    parameter int RAS_TICK = 6,
    parameter int CAS_TICK = 7,
    parameter int RDY_BASE = 11,
    parameter int WS_STEP  = 5,
    parameter int RDY_LEN  = 5,
    parameter int PRE_LEN  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_start,
    input  logic [ADDR_W-1:0]   cyc_addr,
    input  logic                cyc_write,
    input  logic [DATA_W-1:0]   cyc_wdata,
    input  logic [WS_W-1:0]     ws_sel,
    output logic                cyc_ready,
    output logic [DATA_W-1:0]   cyc_rdata,
    output logic                par_err,
    output logic [ADDR_W/2-1:0] dram_a,
    output logic                dram_col,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic [DATA_W-1:0]   dram_dq_o,
    output logic [DATA_W/8-1:0] dram_dp_o,
    input  logic [DATA_W-1:0]   dram_dq_i,
    input  logic [DATA_W/8-1:0] dram_dp_i
);

    logic begin_w, capture_w, busy_w, ras_w, cas_w, col_w, rdy_w, pend_w, cur_we;

    dseq_fsm #(
        .WS_W(WS_W), .RAS_TICK(RAS_TICK), .CAS_TICK(CAS_TICK),
        .RDY_BASE(RDY_BASE), .WS_STEP(WS_STEP), .RDY_LEN(RDY_LEN), .PRE_LEN(PRE_LEN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(cyc_start), .pend_i(pend_w), .ws_i(ws_sel),
        .begin_o(begin_w), .capture_o(capture_w), .busy_o(busy_w),
        .ras_o(ras_w), .cas_o(cas_w), .col_o(col_w), .rdy_o(rdy_w)
    );

    dseq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .start_i(cyc_start), .begin_i(begin_w),
        .busy_i(busy_w), .col_i(col_w), .addr_i(cyc_addr), .we_i(cyc_write),
        .wdata_i(cyc_wdata), .pend_o(pend_w), .cur_we_o(cur_we),
        .cur_wdata_o(dram_dq_o), .mem_a_o(dram_a)
    );

    dseq_parity #(.DATA_W(DATA_W)) u_par (
        .clk(clk), .rst_n(rst_n), .capture_i(capture_w), .cur_we_i(cur_we),
        .wdata_i(dram_dq_o), .rdata_i(dram_dq_i), .rpar_i(dram_dp_i),
        .wpar_o(dram_dp_o), .rdata_o(cyc_rdata), .err_o(par_err)
    );

    assign dram_ras_n = ~ras_w;
    assign dram_cas_n = ~cas_w;
    assign dram_col   = col_w;
    assign cyc_ready  = rdy_w;
    assign dram_we_n  = ~(ras_w && cur_we);

    // R8
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && cur_we) |-> $past(!dram_we_n));

    // R8
    we_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_ras_n);

    // R5
    ready_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ready |-> !dram_cas_n);

endmodule

// File: tb/sim_dram_cycle_seq.sv
`timescale 1ns/1ps
module sim_dram_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [17:0] cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic [15:0] cyc_wdata = '0;
    logic [1:0]  ws_sel = '0;
    logic        cyc_ready;
    logic [15:0] cyc_rdata;
    logic        par_err;
    logic [8:0]  dram_a;
    logic        dram_col, dram_ras_n, dram_cas_n, dram_we_n;
    logic [15:0] dram_dq_o;
    logic [1:0]  dram_dp_o;
    logic [15:0] dram_dq_i = '0;
    logic [1:0]  dram_dp_i = '0;

    int vec = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dram_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .cyc_wdata(cyc_wdata), .ws_sel(ws_sel),
        .cyc_ready(cyc_ready), .cyc_rdata(cyc_rdata), .par_err(par_err),
        .dram_a(dram_a), .dram_col(dram_col), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_o(dram_dq_o),
        .dram_dp_o(dram_dp_o), .dram_dq_i(dram_dq_i), .dram_dp_i(dram_dp_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // parity by counting ones: 1 when the count is even
    function automatic logic pbit(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(b[i]);
        return (n % 2) == 0;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic launch(input logic [17:0] a, input logic wr, input logic [15:0] wd);
        cyc_start = 1'b1;
        cyc_addr  = a;
        cyc_write = wr;
        cyc_wdata = wd;
        step();
        cyc_start = 1'b0;
    endtask

    task automatic check_tick(input int k, input int ws, input logic wr,
                              input logic [17:0] a, input logic [15:0] wd,
                              input logic [15:0] rd, input logic ee, input string etag);
        int  r, e;
        logic ras_e, cas_e, rdy_e, we_e;
        r = 11 + 5 * ws;
        e = r + 5;
        ras_e = (k >= 6) && (k < e);
        cas_e = (k >= 7) && (k < e);
        rdy_e = (k >= r) && (k < e);
        we_e  = wr && ras_e;
        chk("R2", "ras_n", 32'(dram_ras_n), 32'(!ras_e));
        chk("R3", "col", 32'(dram_col), 32'(cas_e));
        chk("R3", "addr pins", 32'(dram_a), cas_e ? 32'(a[17:9]) : 32'(a[8:0]));
        chk("R4", "cas_n", 32'(dram_cas_n), 32'(!cas_e));
        chk("R5", "ready", 32'(cyc_ready), 32'(rdy_e));
        chk("R8", "we_n", 32'(dram_we_n), 32'(!we_e));
        if (rdy_e) begin
            if (wr) begin
                chk("R8", "dq_o", 32'(dram_dq_o), 32'(wd));
                chk("R9", "dp_o", 32'(dram_dp_o), 32'({pbit(wd[15:8]), pbit(wd[7:0])}));
            end else begin
                chk("R10", "rdata", 32'(cyc_rdata), 32'(rd));
                chk(etag, "par_err", 32'(par_err), 32'(ee));
            end
        end
    endtask

    task automatic idle_check(input string req);
        chk(req, "idle ras_n", 32'(dram_ras_n), 32'd1);
        chk(req, "idle cas_n", 32'(dram_cas_n), 32'd1);
        chk(req, "idle ready", 32'(cyc_ready), 32'd0);
    endtask

    task automatic full_cycle(input int ws, input logic wr, input logic [17:0] a,
                              input logic [15:0] wd, input logic [15:0] rd,
                              input logic [1:0] rp, input logic ee, input string etag);
        int e;
        e = 16 + 5 * ws;
        ws_sel    = 2'(ws);
        dram_dq_i = rd;
        dram_dp_i = rp;
        launch(a, wr, wd);
        for (int k = 0; k <= e + 3; k++) begin
            check_tick(k, ws, wr, a, wd, rd, ee, etag);
            step();
        end
        idle_check("R6");
    endtask

    initial begin
        int e;
        logic [15:0] d;
        logic [1:0]  p;
        // R1: reset state
        repeat (3) @(negedge clk);
        idle_check("R1");
        chk("R1", "we_n", 32'(dram_we_n), 32'd1);
        chk("R1", "par_err", 32'(par_err), 32'd0);
        rst_n = 1'b1;
        step();
        idle_check("R1");
        chk("R1", "we_n after reset", 32'(dram_we_n), 32'd1);

        // sweep wait states and directions
        for (int ws = 0; ws < 4; ws++) begin
            for (int w = 0; w < 2; w++) begin
                logic [17:0] a;
                a = {9'(ws * 37 + w * 100 + 1), 9'(~(ws * 53 + w))};
                d = 16'hA5C3 ^ 16'(ws * 16'h1111 + w * 16'h0F0F);
                p = {pbit(d[15:8]), pbit(d[7:0])};
                full_cycle(ws, w[0], a, d, d, p, 1'b0, "R10");
            end
        end

        // R9: parity on assorted write patterns
        full_cycle(0, 1'b1, 18'h3FFFF, 16'h0000, 16'h0, 2'b00, 1'b0, "R10");
        full_cycle(0, 1'b1, 18'h00000, 16'hFFFF, 16'h0, 2'b00, 1'b0, "R10");
        full_cycle(0, 1'b1, 18'h1FE01, 16'h0180, 16'h0, 2'b00, 1'b0, "R10");

        // R10: single flipped bit in every position
        d = 16'h3C96;
        p = {pbit(d[15:8]), pbit(d[7:0])};
        for (int j = 0; j < 16; j++)
            full_cycle(0, 1'b0, 18'(j * 1000 + 7), 16'h0, d ^ (16'h1 << j), p, 1'b1, "R10");
        full_cycle(0, 1'b0, 18'h12345, 16'h0, d, p ^ 2'b01, 1'b1, "R10");
        full_cycle(1, 1'b0, 18'h23456, 16'h0, d ^ 16'h0101, p, 1'b1, "R10");
        // R11: two flips in one byte
        full_cycle(0, 1'b0, 18'h0AAAA, 16'h0, d ^ 16'h0003, p, 1'b0, "R11");
        full_cycle(2, 1'b0, 18'h15555, 16'h0, d ^ 16'h8100 ^ 16'h0100 ^ 16'h4000, p, 1'b0, "R11");
        // a write clears the flag
        full_cycle(0, 1'b0, 18'h00111, 16'h0, d ^ 16'h0010, p, 1'b1, "R10");
        full_cycle(0, 1'b1, 18'h00222, 16'h5A5A, 16'h0, 2'b00, 1'b0, "R10");
        chk("R10", "par_err after write", 32'(par_err), 32'd0);

        // R12: change of wait states during a cycle
        ws_sel = 2'd0;
        dram_dq_i = 16'h0F0F;
        dram_dp_i = {pbit(8'h0F), pbit(8'h0F)};
        launch(18'h2B3C4, 1'b0, 16'h0);
        for (int k = 0; k <= 19; k++) begin
            check_tick(k, 0, 1'b0, 18'h2B3C4, 16'h0, 16'h0F0F, 1'b0, "R10");
            chk("R12", "ready under changed ws", 32'(cyc_ready), 32'((k >= 11) && (k < 16)));
            if (k == 3) ws_sel = 2'd3;
            step();
        end
        idle_check("R12");

        // R7: strobes injected mid-cycle and in precharge, and a dropped third
        for (int v = 0; v < 3; v++) begin
            logic [17:0] a, b;
            int inj;
            a = 18'h1C0E3 + 18'(v * 3);
            b = 18'h063F1 + 18'(v * 5);
            ws_sel = 2'd1;
            e = 21;
            inj = (v == 1) ? e + 1 : 10;
            dram_dq_i = 16'h0;
            dram_dp_i = 2'b11;
            launch(a, 1'b0, 16'h0);
            for (int k = 0; k <= e + 3; k++) begin
                check_tick(k, 1, 1'b0, a, 16'h0, 16'h0, 1'b0, "R10");
                if (k == inj) begin
                    cyc_start = 1'b1;
                    cyc_addr  = b;
                    cyc_write = 1'b1;
                    cyc_wdata = 16'h7E81;
                end
                if (v == 2 && k == 12) begin
                    cyc_start = 1'b1;
                    cyc_addr  = 18'h3FFFF;
                    cyc_write = 1'b0;
                end
                step();
                cyc_start = 1'b0;
            end
            for (int k = 0; k <= e + 3; k++) begin
                check_tick(k, 1, 1'b1, b, 16'h7E81, 16'h0, 1'b0, "R10");
                chk("R7", "queued ras_n", 32'(dram_ras_n), 32'(!((k >= 6) && (k < e))));
                chk("R7", "queued addr", 32'(dram_a),
                    ((k >= 7) && (k < e)) ? 32'(b[17:9]) : 32'(b[8:0]));
                step();
            end
            for (int k = 0; k < 8; k++) begin
                idle_check("R7");
                step();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: got still running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule